// File: doc/BRIEF.md
# Burst Target Address Sequencer

This block sits in the target side of a 32-bit multiplexed address/data bus interface. It produces the address for every data phase of a burst. On the address-phase strobe it captures the start address and, for memory space, the two low address bits that pick the burst ordering. Each completed data phase then moves the address according to that ordering. Wait states, meaning cycles with no completion strobe, leave the address alone.

Three memory orderings exist. Code 00 is a linear burst. Code 10 is a cache-line wrap: the address climbs to the end of the line, wraps to the line base, and after a whole line moves to the starting offset in the next line. Codes 01 and 11 are reserved. A reserved code, or a wrap request while wrap support is switched off, raises a disconnect request after the first data phase.

For I/O space the low bits are a byte address and carry no ordering meaning. Instead the block checks, on every data phase, that the active-low byte enables agree with that byte address.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and directly after it is released, `cur_addr` is 0 and `disc_req` and `be_err` are 0.
- R2: One cycle after `addr_phase`, `cur_addr` holds the captured start address. For memory space this is `ad_in` with bits [1:0] cleared. For I/O space (`io_space`=1) it is `ad_in` unchanged.
- R3: In a memory burst with ordering code `ad_in[1:0]`=00, each `data_done` advances `cur_addr` by 4 in the following cycle.
- R4: In a cycle with neither `addr_phase` nor `data_done`, `cur_addr` does not change in the next cycle.
- R5: In a memory burst with code 10 and `wrap_en`=1, the line length is 4, 8, 16 or 32 DWORDs for `line_sel` = 0, 1, 2 or 3. Each `data_done` moves the address to the next DWORD of the same line, and the last DWORD of the line is followed by the line base.
- R6: In a wrap burst, once a full line of data phases has completed, the next address is the starting offset within the following line. A wrap that starts on a line boundary therefore produces the linear sequence.
- R7: For memory codes 01 and 11, `disc_req` rises in the cycle after the first `data_done`. `cur_addr` does not advance during such a burst.
- R8: For memory code 10 with `wrap_en`=0, the block behaves as in R7.
- R9: Once `disc_req` is set, it stays at 1 until the next `addr_phase`, which clears it one cycle later.
- R10: For an I/O burst with captured byte address k = `ad_in[1:0]`, a data phase is legal when `cbe_n[k]`=0 and every `cbe_n[j]` with j<k is 1. Each `data_done` of an I/O burst loads `be_err` with 1 if the phase was illegal and 0 if it was legal. `addr_phase` clears `be_err`. Memory bursts never set `be_err`.
- R11: An I/O burst ignores the ordering code. Each `data_done` adds 4 to `cur_addr` while keeping bits [1:0], and `disc_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_phase | input | 1 | Address-phase strobe; captures `ad_in`, `io_space`, `wrap_en`, `line_sel` |
| data_done | input | 1 | Data-phase-complete strobe |
| ad_in | input | 32 | Address bus value during the address phase |
| cbe_n | input | 4 | Active-low byte enables of the current data phase |
| io_space | input | 1 | 1 = I/O-space access, 0 = memory-space access |
| wrap_en | input | 1 | 1 = cache-line wrap supported |
| line_sel | input | 2 | Cache line length: 4 << line_sel DWORDs |
| cur_addr | output | 32 | Address of the current data phase |
| disc_req | output | 1 | Disconnect request, sticky until the next address phase |
| be_err | output | 1 | Byte enables of the last I/O data phase disagreed with the byte address |

## Verification
Linear bursts are interleaved with idle cycles, which separates stepping on the completion strobe from stepping on every clock. Wrap bursts are run from mid-line starts at three line lengths and compared with a modular model. This distinguishes a correct wrap point and next-line offset from a wrong line mask or a restart at the line base. A wrap from a line boundary with the largest line is compared against a pure linear sequence.

Reserved codes and disabled wrap are each driven for several phases and idle cycles, to show that the disconnect is sticky and that the address is frozen. I/O bursts sweep all four byte addresses with legal and illegal enable patterns, showing that the flag is updated per phase and that the low bits survive stepping. A memory burst driven with bad enables shows that memory bursts are exempt from the check.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BUS_W            = 32;
  localparam int SEL_W            = 2;
  localparam int BE_W             = BUS_W / 8;
  localparam int MIN_LINE_DW_LOG2 = 2;
  localparam int MAX_LINE_DW_LOG2 = MIN_LINE_DW_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W            = MAX_LINE_DW_LOG2 + 1;

  typedef logic [BUS_W-1:0] addr_t;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'd0,
    ORD_WRAP   = 2'd1,
    ORD_STOP   = 2'd2,
    ORD_IO     = 2'd3
  } ord_e;

  // Ordering chosen at the address phase
  function automatic ord_e ord_decode(input logic [1:0] code, input logic io,
                                      input logic wrap_en);
    if (io) return ORD_IO;
    case (code)
      2'b00:   return ORD_LINEAR;
      2'b10:   return wrap_en ? ORD_WRAP : ORD_STOP;
      default: return ORD_STOP;
    endcase
  endfunction

  // Number of DWORDs in a cache line for a given size select
  function automatic logic [CNT_W-1:0] line_dwords(input logic [SEL_W-1:0] sel);
    return CNT_W'(1) << (MIN_LINE_DW_LOG2 + int'(sel));
  endfunction

  // Byte-offset mask of a cache line
  function automatic addr_t line_mask(input logic [SEL_W-1:0] sel);
    return (addr_t'(line_dwords(sel)) << 2) - addr_t'(1);
  endfunction

  // Byte enables legal for an I/O byte address
  function automatic logic be_ok(input logic [1:0] low, input logic [BE_W-1:0] be_n);
    logic ok;
    ok = !be_n[low];
    for (int j = 0; j < BE_W; j++)
      if (j < int'(low) && !be_n[j]) ok = 1'b0;
    return ok;
  endfunction

  // Next address of a wrapping burst
  function automatic addr_t wrap_next(input addr_t cur, input addr_t start_off,
                                      input logic [SEL_W-1:0] sel, input logic line_end);
    addr_t m;
    m = line_mask(sel);
    if (line_end) return (cur & ~m) + m + addr_t'(1) + start_off;
    return (cur & ~m) | ((cur + addr_t'(4)) & m);
  endfunction
endpackage

// File: rtl/bas_mode.sv
module bas_mode
  import bas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             data_done,
  input  logic [1:0]       ad_low,
  input  logic             io_space,
  input  logic             wrap_en,
  input  logic [SEL_W-1:0] line_sel,
  output ord_e             ord_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [1:0]       low_q,
  output logic             disc_req
);
  logic disc_fire;
  assign disc_fire = data_done && !addr_phase && (ord_q == ORD_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ord_q    <= ORD_LINEAR;
      sel_q    <= '0;
      low_q    <= '0;
      disc_req <= 1'b0;
    end else if (addr_phase) begin
      ord_q    <= ord_decode(ad_low, io_space, wrap_en);
      sel_q    <= line_sel;
      low_q    <= ad_low;
      disc_req <= 1'b0;
    end else if (disc_fire) begin
      disc_req <= 1'b1;
    end
  end

  AST_DISC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req && !addr_phase |=> disc_req);                              // R9
  AST_DISC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !disc_req);                                          // R9
  AST_DISC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_req) |-> ord_q == ORD_STOP);                             // R7
  AST_IO_NO_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    ord_q == ORD_IO && !$past(addr_phase) |-> !disc_req);               // R11
endmodule

// File: rtl/bas_step.sv
module bas_step
  import bas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             data_done,
  input  addr_t            ad_in,
  input  logic             io_space,
  input  logic [SEL_W-1:0] line_sel,
  input  ord_e             ord_q,
  input  logic [SEL_W-1:0] sel_q,
  output addr_t            cur_addr
);
  logic [CNT_W-1:0] cnt;
  addr_t            start_off;
  logic             step_fire;
  logic             wrap_line_end;

  assign step_fire     = data_done && !addr_phase;
  assign wrap_line_end = (cnt + CNT_W'(1)) == line_dwords(sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cnt       <= '0;
      start_off <= '0;
    end else if (addr_phase) begin
      cur_addr  <= io_space ? ad_in : (ad_in & ~addr_t'(3));
      cnt       <= '0;
      start_off <= ad_in & line_mask(line_sel) & ~addr_t'(3);
    end else if (step_fire) begin
      case (ord_q)
        ORD_LINEAR, ORD_IO: cur_addr <= cur_addr + addr_t'(4);
        ORD_WRAP: begin
          cur_addr <= wrap_next(cur_addr, start_off, sel_q, wrap_line_end);
          cnt      <= wrap_line_end ? '0 : cnt + CNT_W'(1);
        end
        default: cur_addr <= cur_addr;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_phase && !data_done |=> $stable(cur_addr));                   // R4
  AST_LINEAR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && ord_q == ORD_LINEAR |=> cur_addr == $past(cur_addr) + addr_t'(4)); // R3
  AST_WRAP_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && ord_q == ORD_WRAP && !wrap_line_end
    |=> ((cur_addr ^ $past(cur_addr)) & ~line_mask(sel_q)) == '0);      // R5
  AST_WRAP_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && ord_q == ORD_WRAP && wrap_line_end
    |=> (cur_addr & line_mask(sel_q)) == start_off);                    // R6
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && ord_q == ORD_STOP |=> $stable(cur_addr));              // R7
  AST_IO_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && ord_q == ORD_IO |=> cur_addr[1:0] == $past(cur_addr[1:0])); // R11
endmodule

// File: rtl/bas_bechk.sv
module bas_bechk
  import bas_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_phase,
  input  logic            data_done,
  input  ord_e            ord_q,
  input  logic [1:0]      low_q,
  input  logic [BE_W-1:0] cbe_n,
  output logic            be_err
);
  logic io_phase;
  logic phase_bad;

  assign io_phase  = data_done && !addr_phase && (ord_q == ORD_IO);
  assign phase_bad = !be_ok(low_q, cbe_n);

  always_ff @(posedge clk) begin
    if (!rst_n)         be_err <= 1'b0;
    else if (addr_phase) be_err <= 1'b0;
    else if (io_phase)   be_err <= phase_bad;
  end

  AST_BE_MEM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    be_err |-> ord_q == ORD_IO);                                        // R10
  AST_BE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !be_err);                                            // R10
  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_phase && !data_done |=> $stable(be_err));                     // R10
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic              data_done,
  input  logic [BUS_W-1:0]  ad_in,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              io_space,
  input  logic              wrap_en,
  input  logic [SEL_W-1:0]  line_sel,
  output logic [BUS_W-1:0]  cur_addr,
  output logic              disc_req,
  output logic              be_err
);
  ord_e             ord_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       low_q;

  bas_mode u_mode (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .data_done(data_done),
    .ad_low(ad_in[1:0]), .io_space(io_space), .wrap_en(wrap_en),
    .line_sel(line_sel), .ord_q(ord_q), .sel_q(sel_q), .low_q(low_q),
    .disc_req(disc_req)
  );

  bas_step u_step (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .data_done(data_done),
    .ad_in(ad_in), .io_space(io_space), .line_sel(line_sel), .ord_q(ord_q),
    .sel_q(sel_q), .cur_addr(cur_addr)
  );

  bas_bechk u_bechk (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .data_done(data_done),
    .ord_q(ord_q), .low_q(low_q), .cbe_n(cbe_n), .be_err(be_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> cur_addr == '0 && !disc_req && !be_err);                 // R1
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_phase = 1'b0;
  logic        data_done = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        io_space = 1'b0;
  logic        wrap_en = 1'b0;
  logic [1:0]  line_sel = '0;
  logic [31:0] cur_addr;
  logic        disc_req;
  logic        be_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .data_done(data_done),
    .ad_in(ad_in), .cbe_n(cbe_n), .io_space(io_space), .wrap_en(wrap_en),
    .line_sel(line_sel), .cur_addr(cur_addr), .disc_req(disc_req), .be_err(be_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] a, input logic io, input logic we,
                       input logic [1:0] sel);
    @(negedge clk);
    addr_phase = 1'b1; ad_in = a; io_space = io; wrap_en = we; line_sel = sel;
    @(negedge clk);
    addr_phase = 1'b0; ad_in = 32'hDEAD_BEEF; io_space = ~io; wrap_en = ~we;
  endtask

  task automatic phase(input logic [3:0] be);
    @(negedge clk);
    data_done = 1'b1; cbe_n = be;
    @(negedge clk);
    data_done = 1'b0; cbe_n = 4'hF;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Independent model: k phases after a wrap start
  function automatic logic [31:0] wrap_exp(input logic [31:0] s, input int sel, input int k);
    int unsigned len, nd, base, off;
    len  = 16 << sel;
    nd   = len / 4;
    base = s & ~(len - 1);
    off  = s & (len - 1) & ~32'd3;
    return 32'(base + (k / nd) * len + ((off + 4 * (k % nd)) % len));
  endfunction

  task automatic t_reset;
    check("R1 addr", cur_addr, 0);
    check("R1 disc", {31'd0, disc_req}, 0);
    check("R1 be", {31'd0, be_err}, 0);
  endtask

  task automatic t_latch;
    start(32'h1234_567B, 1'b0, 1'b1, 2'd0);
    check("R2 mem", cur_addr, 32'h1234_5678);
    start(32'h0000_1003, 1'b1, 1'b0, 2'd0);
    check("R2 io", cur_addr, 32'h0000_1003);
  endtask

  task automatic t_linear;
    start(32'h0000_1000, 1'b0, 1'b0, 2'd1);
    for (int k = 1; k <= 3; k++) begin
      phase(4'h0);
      check("R3 linear", cur_addr, 32'h1000 + 4 * k);
      idle(k);
      check("R4 wait", cur_addr, 32'h1000 + 4 * k);
    end
    check("R3 nodisc", {31'd0, disc_req}, 0);
  endtask

  task automatic t_wrap(input logic [31:0] s, input int sel, input int n);
    start(s | 32'h2, 1'b0, 1'b1, 2'(sel));
    check("R5 start", cur_addr, s);
    for (int k = 1; k <= n; k++) begin
      phase(4'h0);
      if (k % (4 << sel) == 0) check("R6 nextline", cur_addr, wrap_exp(s, sel, k));
      else                     check("R5 wrap", cur_addr, wrap_exp(s, sel, k));
      if (k == 2) begin
        idle(2);
        check("R4 wrapwait", cur_addr, wrap_exp(s, sel, k));
      end
    end
    check("R5 nodisc", {31'd0, disc_req}, 0);
  endtask

  task automatic t_wrap_example;
    start(32'h0000_2008 | 32'h2, 1'b0, 1'b1, 2'd0);
    phase(4'h0); check("R5 ex", cur_addr, 32'h200C);
    phase(4'h0); check("R5 ex", cur_addr, 32'h2000);
    phase(4'h0); check("R5 ex", cur_addr, 32'h2004);
    phase(4'h0); check("R6 ex", cur_addr, 32'h2018);
  endtask

  task automatic t_boundary;
    start(32'h0000_4000 | 32'h2, 1'b0, 1'b1, 2'd3);
    for (int k = 1; k <= 40; k++) begin
      phase(4'h0);
      check("R6 boundary", cur_addr, 32'h4000 + 4 * k);
    end
  endtask

  task automatic t_stop(input logic [1:0] code, input logic we, input string req);
    start(32'h0000_6000 | {30'd0, code}, 1'b0, we, 2'd0);
    check(req, {31'd0, disc_req}, 0);
    phase(4'h0);
    check(req, {31'd0, disc_req}, 1);
    check(req, cur_addr, 32'h6000);
    phase(4'h0);
    idle(3);
    check("R9 sticky", {31'd0, disc_req}, 1);
    check(req, cur_addr, 32'h6000);
    start(32'h0000_6100, 1'b0, 1'b0, 2'd0);
    check("R9 clear", {31'd0, disc_req}, 0);
  endtask

  task automatic t_io;
    start(32'h0000_7002, 1'b1, 1'b0, 2'd0);
    phase(4'b1011); check("R10 legal", {31'd0, be_err}, 0);
    check("R11 step", cur_addr, 32'h7006);
    phase(4'b0011); check("R10 legal2", {31'd0, be_err}, 0);
    phase(4'b1001); check("R10 lowbyte", {31'd0, be_err}, 1);
    idle(2);        check("R10 held", {31'd0, be_err}, 1);
    phase(4'b1011); check("R10 recover", {31'd0, be_err}, 0);
    check("R11 step4", cur_addr, 32'h7012);
    check("R11 nodisc", {31'd0, disc_req}, 0);
    phase(4'b1001);
    start(32'h0000_7103, 1'b1, 1'b0, 2'd0);
    check("R10 clear", {31'd0, be_err}, 0);
    phase(4'b0111); check("R10 b3ok", {31'd0, be_err}, 0);
    phase(4'b1111); check("R10 b3off", {31'd0, be_err}, 1);
    check("R11 low", cur_addr, 32'h710B);
    start(32'h0000_7201, 1'b1, 1'b1, 2'd0);
    phase(4'b1100); check("R10 b0on", {31'd0, be_err}, 1);
    phase(4'b1101); check("R10 b1ok", {31'd0, be_err}, 0);
    start(32'h0000_7300, 1'b1, 1'b0, 2'd0);
    phase(4'b0000); check("R10 b0all", {31'd0, be_err}, 0);
    phase(4'b0001); check("R10 b0off", {31'd0, be_err}, 1);
    start(32'h0000_7400, 1'b0, 1'b0, 2'd0);
    phase(4'b1111); check("R10 mem", {31'd0, be_err}, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_linear();
    t_wrap_example();
    t_wrap(32'h0000_2008, 0, 9);
    t_wrap(32'h0000_3014, 1, 18);
    t_wrap(32'h0000_5038, 2, 20);
    t_boundary();
    t_stop(2'b01, 1'b1, "R7 code01");
    t_stop(2'b11, 1'b1, "R7 code11");
    t_stop(2'b10, 1'b0, "R8 nowrap");
    t_io();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule